// File: doc/BRIEF.md
# Paired UART Transmit/Receive Queues with Service Thresholds

This block sits between a UART's serializer and deserializer and whatever moves bytes to and from them. It holds two queues of equal depth: one carries plain bytes towards the line, and one carries received bytes towards the host. Each received byte is stored with a 4-bit error status. All pushes and pops are single-cycle strobes. The head entry of each queue is always visible on the read outputs, and a pop advances past it.

Each direction raises a level-sensitive service request. The receive side raises it once the queue reaches a selectable fill. The transmit side raises it once the queue has drained to a selectable level. A sticky error-present indication stays up while any stored receive entry carries an error, so software knows it must read the error status. When the queue enable is low, each direction collapses to a single holding register. Each direction has its own flush strobe.

Top module: `uart_fifo_pair`

## Requirements
- R1: With `fifo_en` high, each queue holds DEPTH (16) entries in arrival order. The count output shows the occupancy modulo 16, so a full queue reads count 0 with its full flag set.
- R2: A push into a full transmit queue is dropped and changes neither the count nor the stored data. A pop on an empty queue is ignored.
- R3: Each receive entry carries an error status. Bit 0 is overrun, bit 1 is parity, bit 2 is frame and bit 3 is break. The input `rx_wr_flags` supplies parity on [0], frame on [1] and break on [2].
- R4: A push into a full receive queue drops the byte and sets the overrun bit (bit 0) of the most recently stored entry.
- R5: A push and a pop in the same cycle on a full queue are both accepted, and the queue stays full.
- R6: With the queues enabled, `rx_req` is high while the receive occupancy is at least 4, 8, 12 or 16, for `rx_trig_sel` values 0, 1, 2 and 3 respectively.
- R7: With the queues enabled, `tx_trig_sel` value 0 raises `tx_req` only when the transmit queue is empty. Values 1, 2 and 3 raise it while the occupancy is at most 4, 8 or 12.
- R8: A one-cycle `rx_clr` or `tx_clr` strobe empties only that queue at the next clock edge. Clearing the receive queue also drops `rx_err_present`.
- R9: `rx_err_present` rises the cycle after an entry with a non-zero error status is stored. It stays high until the last such entry has been popped.
- R10: With `fifo_en` low, each queue holds one entry and reports full at one entry. `rx_req` is high while that entry is present and `tx_req` is high while the transmit holding register is empty. Any change of `fifo_en` flushes both queues.
- R11: After reset, both counts are 0, no queue is full, `rx_req` and `rx_err_present` are low, and `tx_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1: full-depth queues, 0: single holding register per direction |
| rx_clr | input | 1 | Flush strobe for the receive queue |
| tx_clr | input | 1 | Flush strobe for the transmit queue |
| rx_trig_sel | input | 2 | Receive service threshold code |
| tx_trig_sel | input | 2 | Transmit service threshold code |
| tx_push | input | 1 | Write strobe for the transmit queue |
| tx_wr_data | input | DATA_W | Byte to enqueue for transmission |
| tx_pop | input | 1 | Serializer takes the head byte |
| tx_rd_data | output | DATA_W | Head byte of the transmit queue |
| tx_count | output | 4 | Transmit occupancy modulo DEPTH |
| tx_full | output | 1 | Transmit queue full |
| tx_req | output | 1 | Transmit service request |
| rx_push | input | 1 | Deserializer delivers a byte |
| rx_wr_data | input | DATA_W | Received byte |
| rx_wr_flags | input | 3 | Line errors of the received byte: parity, frame, break |
| rx_pop | input | 1 | Host takes the head entry |
| rx_rd_data | output | DATA_W | Head byte of the receive queue |
| rx_rd_err | output | 4 | Error status of the head entry |
| rx_count | output | 4 | Receive occupancy modulo DEPTH |
| rx_full | output | 1 | Receive queue full |
| rx_req | output | 1 | Receive service request |
| rx_err_present | output | 1 | Some stored receive entry carries an error |

## Verification
The bound checker watches several properties on every cycle. It checks the full-reads-as-zero count encoding, the empty condition of transmit code 0, the single-entry limit while disabled, and the effect of a flush strobe. It also checks that a dropped transmit push leaves the queue untouched, and that the error indication neither drops without a pop, flush or mode change nor stays up over an empty queue. Other properties need a chosen history and are left to the bench's scenarios. These are arrival order, the exact threshold crossings for every code, overrun landing on the newest entry, and the error indication outliving earlier errored entries.

// File: rtl/ufifo_pkg.sv
package ufifo_pkg;
   localparam int ERR_W  = 4;
   localparam int TRIG_W = 2;
   localparam int LINE_FLAG_W = 3;

   // error status bit positions (bit order is visible at the ports)
   localparam int ERR_OVR = 0;
   localparam int ERR_PAR = 1;
   localparam int ERR_FRM = 2;
   localparam int ERR_BRK = 3;

   // line flags arrive as {break, frame, parity}; overrun is added here
   function automatic logic [ERR_W-1:0] err_pack(input logic [LINE_FLAG_W-1:0] flags);
      logic [ERR_W-1:0] e;
      e          = '0;
      e[ERR_PAR] = flags[0];
      e[ERR_FRM] = flags[1];
      e[ERR_BRK] = flags[2];
      return e;
   endfunction

   function automatic logic [ERR_W-1:0] ovr_mask();
      logic [ERR_W-1:0] e;
      e          = '0;
      e[ERR_OVR] = 1'b1;
      return e;
   endfunction
endpackage

// File: rtl/ufifo_store.sv
module ufifo_store #(
   parameter int W        = 8,
   parameter int DEPTH    = 16,
   parameter bit MARKABLE = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic [$clog2(DEPTH):0]   cap,
   input  logic                     push,
   input  logic                     pop,
   input  logic [W-1:0]             wdata,
   input  logic [W-1:0]             mark_mask,
   output logic [W-1:0]             head,
   output logic [W-1:0]             tail,
   output logic [$clog2(DEPTH):0]   occ,
   output logic                     full,
   output logic                     push_ok,
   output logic                     pop_ok,
   output logic                     mark_ok
);
   localparam int PW = $clog2(DEPTH);
   localparam int OW = PW + 1;

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;

   always_comb begin
      full    = (occ >= cap);
      pop_ok  = pop && (occ != '0);
      push_ok = push && (!full || pop_ok);
      head    = mem[rd_ptr];
      tail    = mem[wr_ptr - 1'b1];
   end

   generate
      if (MARKABLE) begin : g_mark
         assign mark_ok = push && full && !pop_ok;
      end else begin : g_nomark
         assign mark_ok = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         occ    <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         occ    <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         occ <= occ + OW'(push_ok) - OW'(pop_ok);
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok)
         mem[wr_ptr] <= wdata;
      else if (mark_ok)
         mem[wr_ptr - 1'b1] <= tail | mark_mask;
   end
endmodule

// File: rtl/ufifo_level.sv
module ufifo_level #(
   parameter int DEPTH   = 16,
   parameter bit RX_SIDE = 1'b1
) (
   input  logic                   en,
   input  logic [1:0]             sel,
   input  logic [$clog2(DEPTH):0] occ,
   output logic                   req
);
   localparam int OW   = $clog2(DEPTH) + 1;
   localparam int STEP = DEPTH / 4;

   logic [OW-1:0] thr;

   generate
      if (RX_SIDE) begin : g_rx
         // fill-up threshold: one to four quarters of the depth
         always_comb begin
            thr = OW'((int'(sel) + 1) * STEP);
            req = en ? (occ >= thr) : (occ != '0);
         end
      end else begin : g_tx
         // drain threshold: code 0 gives zero, i.e. empty
         always_comb begin
            thr = OW'(int'(sel) * STEP);
            req = en ? (occ <= thr) : (occ == '0);
         end
      end
   endgenerate
endmodule

// File: rtl/ufifo_errtrack.sv
module ufifo_errtrack #(
   parameter int DEPTH = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic add_new,
   input  logic add_mark,
   input  logic drop,
   output logic present
);
   localparam int CW = $clog2(DEPTH) + 1;

   logic [CW-1:0] n_err;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         n_err <= '0;
      else if (clr)
         n_err <= '0;
      else
         n_err <= n_err + CW'(add_new | add_mark) - CW'(drop);
   end

   assign present = (n_err != '0);
endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
   import ufifo_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     fifo_en,
   input  logic                     rx_clr,
   input  logic                     tx_clr,
   input  logic [TRIG_W-1:0]        rx_trig_sel,
   input  logic [TRIG_W-1:0]        tx_trig_sel,
   input  logic                     tx_push,
   input  logic [DATA_W-1:0]        tx_wr_data,
   input  logic                     tx_pop,
   output logic [DATA_W-1:0]        tx_rd_data,
   output logic [$clog2(DEPTH)-1:0] tx_count,
   output logic                     tx_full,
   output logic                     tx_req,
   input  logic                     rx_push,
   input  logic [DATA_W-1:0]        rx_wr_data,
   input  logic [LINE_FLAG_W-1:0]   rx_wr_flags,
   input  logic                     rx_pop,
   output logic [DATA_W-1:0]        rx_rd_data,
   output logic [ERR_W-1:0]         rx_rd_err,
   output logic [$clog2(DEPTH)-1:0] rx_count,
   output logic                     rx_full,
   output logic                     rx_req,
   output logic                     rx_err_present
);
   localparam int PW   = $clog2(DEPTH);
   localparam int OW   = PW + 1;
   localparam int RX_W = DATA_W + ERR_W;

   generate
      if (DEPTH < 4 || (DEPTH % 4) != 0 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 4");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be positive");
      end
   endgenerate

   // mode tracking: a change of fifo_en flushes both directions
   logic          en_q;
   logic          flush;
   logic [OW-1:0] cap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b1;
      else        en_q <= fifo_en;
   end

   assign flush = (fifo_en != en_q);
   assign cap   = fifo_en ? OW'(DEPTH) : OW'(1);

   // transmit direction
   logic [OW-1:0]     tx_occ;
   logic [DATA_W-1:0] tx_tail_unused;
   logic              tx_push_ok_unused, tx_pop_ok_unused, tx_mark_unused;

   ufifo_store #(.W(DATA_W), .DEPTH(DEPTH), .MARKABLE(1'b0)) u_tx_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (tx_clr | flush),
      .cap       (cap),
      .push      (tx_push),
      .pop       (tx_pop),
      .wdata     (tx_wr_data),
      .mark_mask ('0),
      .head      (tx_rd_data),
      .tail      (tx_tail_unused),
      .occ       (tx_occ),
      .full      (tx_full),
      .push_ok   (tx_push_ok_unused),
      .pop_ok    (tx_pop_ok_unused),
      .mark_ok   (tx_mark_unused)
   );

   ufifo_level #(.DEPTH(DEPTH), .RX_SIDE(1'b0)) u_tx_level (
      .en  (fifo_en),
      .sel (tx_trig_sel),
      .occ (tx_occ),
      .req (tx_req)
   );

   assign tx_count = tx_occ[PW-1:0];

   // receive direction: entry = {error status, byte}
   logic [OW-1:0]     rx_occ;
   logic [RX_W-1:0]   rx_head, rx_tail;
   logic [ERR_W-1:0]  rx_tail_err;
   logic [DATA_W-1:0] rx_tail_data_unused;
   logic              rx_push_ok, rx_pop_ok, rx_mark_ok;

   ufifo_store #(.W(RX_W), .DEPTH(DEPTH), .MARKABLE(1'b1)) u_rx_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (rx_clr | flush),
      .cap       (cap),
      .push      (rx_push),
      .pop       (rx_pop),
      .wdata     ({err_pack(rx_wr_flags), rx_wr_data}),
      .mark_mask ({ovr_mask(), {DATA_W{1'b0}}}),
      .head      (rx_head),
      .tail      (rx_tail),
      .occ       (rx_occ),
      .full      (rx_full),
      .push_ok   (rx_push_ok),
      .pop_ok    (rx_pop_ok),
      .mark_ok   (rx_mark_ok)
   );

   assign {rx_rd_err, rx_rd_data}             = rx_head;
   assign {rx_tail_err, rx_tail_data_unused}  = rx_tail;

   ufifo_level #(.DEPTH(DEPTH), .RX_SIDE(1'b1)) u_rx_level (
      .en  (fifo_en),
      .sel (rx_trig_sel),
      .occ (rx_occ),
      .req (rx_req)
   );

   ufifo_errtrack #(.DEPTH(DEPTH)) u_errtrack (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (rx_clr | flush),
      .add_new  (rx_push_ok && (rx_wr_flags != '0)),
      .add_mark (rx_mark_ok && (rx_tail_err == '0)),
      .drop     (rx_pop_ok && (rx_rd_err != '0)),
      .present  (rx_err_present)
   );

   assign rx_count = rx_occ[PW-1:0];
endmodule

// File: rtl/ufifo_chk.sv
module ufifo_chk #(
   parameter int DEPTH = 16
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     fifo_en,
   input logic                     rx_clr,
   input logic                     tx_clr,
   input logic [1:0]               tx_trig_sel,
   input logic                     tx_push,
   input logic                     tx_pop,
   input logic                     rx_pop,
   input logic [$clog2(DEPTH)-1:0] tx_count,
   input logic                     tx_full,
   input logic                     tx_req,
   input logic [$clog2(DEPTH)-1:0] rx_count,
   input logic                     rx_full,
   input logic                     rx_err_present
);
   // R1
   rx_full_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_en && rx_full |-> rx_count == '0);
   // R1
   tx_full_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_en && tx_full |-> tx_count == '0);
   // R2
   tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_full && tx_push && !tx_pop && !tx_clr && $stable(fifo_en)
      |=> tx_full && $stable(tx_count));
   // R7
   tx_empty_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_en && tx_trig_sel == 2'd0 |-> tx_req == (tx_count == '0 && !tx_full));
   // R8
   rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_clr |=> rx_count == '0 && !rx_full && !rx_err_present);
   // R8
   tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_clr |=> tx_count == '0 && !tx_full);
   // R9
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_err_present && !rx_pop && !rx_clr && $stable(fifo_en) |=> rx_err_present);
   // R9
   err_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_err_present |-> (rx_count != '0 || rx_full));
   // R10
   single_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en && $stable(fifo_en) |-> rx_count <= 1 && tx_count <= 1);
endmodule

bind uart_fifo_pair ufifo_chk #(.DEPTH(DEPTH)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .fifo_en        (fifo_en),
   .rx_clr         (rx_clr),
   .tx_clr         (tx_clr),
   .tx_trig_sel    (tx_trig_sel),
   .tx_push        (tx_push),
   .tx_pop         (tx_pop),
   .rx_pop         (rx_pop),
   .tx_count       (tx_count),
   .tx_full        (tx_full),
   .tx_req         (tx_req),
   .rx_count       (rx_count),
   .rx_full        (rx_full),
   .rx_err_present (rx_err_present)
);

// File: tb/tb_uart_fifo_pair.sv
module tb_uart_fifo_pair;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fifo_en = 1'b1, rx_clr = 1'b0, tx_clr = 1'b0;
   logic [1:0] rx_trig_sel = 2'd0, tx_trig_sel = 2'd0;
   logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
   logic [7:0] tx_wr_data = '0, rx_wr_data = '0;
   logic [2:0] rx_wr_flags = '0;
   logic [7:0] tx_rd_data, rx_rd_data;
   logic [3:0] tx_count, rx_count, rx_rd_err;
   logic       tx_full, tx_req, rx_full, rx_req, rx_err_present;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   uart_fifo_pair dut (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_clr(rx_clr), .tx_clr(tx_clr),
      .rx_trig_sel(rx_trig_sel), .tx_trig_sel(tx_trig_sel),
      .tx_push(tx_push), .tx_wr_data(tx_wr_data), .tx_pop(tx_pop),
      .tx_rd_data(tx_rd_data), .tx_count(tx_count), .tx_full(tx_full), .tx_req(tx_req),
      .rx_push(rx_push), .rx_wr_data(rx_wr_data), .rx_wr_flags(rx_wr_flags), .rx_pop(rx_pop),
      .rx_rd_data(rx_rd_data), .rx_rd_err(rx_rd_err), .rx_count(rx_count), .rx_full(rx_full),
      .rx_req(rx_req), .rx_err_present(rx_err_present)
   );

   // {is_rx, trigger code, entries pushed, expected request}
   localparam logic [8:0] VEC [16] = '{
      {1'b1, 2'd0, 5'd3,  1'b0}, {1'b1, 2'd0, 5'd4,  1'b1},
      {1'b1, 2'd1, 5'd7,  1'b0}, {1'b1, 2'd1, 5'd8,  1'b1},
      {1'b1, 2'd2, 5'd11, 1'b0}, {1'b1, 2'd2, 5'd12, 1'b1},
      {1'b1, 2'd3, 5'd15, 1'b0}, {1'b1, 2'd3, 5'd16, 1'b1},
      {1'b0, 2'd0, 5'd0,  1'b1}, {1'b0, 2'd0, 5'd1,  1'b0},
      {1'b0, 2'd1, 5'd4,  1'b1}, {1'b0, 2'd1, 5'd5,  1'b0},
      {1'b0, 2'd2, 5'd8,  1'b1}, {1'b0, 2'd2, 5'd9,  1'b0},
      {1'b0, 2'd3, 5'd12, 1'b1}, {1'b0, 2'd3, 5'd13, 1'b0}
   };

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic push_tx(input logic [7:0] d);
      tx_push = 1'b1; tx_wr_data = d; cyc(); tx_push = 1'b0;
   endtask

   task automatic push_rx(input logic [7:0] d, input logic [2:0] f);
      rx_push = 1'b1; rx_wr_data = d; rx_wr_flags = f; cyc();
      rx_push = 1'b0; rx_wr_flags = '0;
   endtask

   task automatic pop_tx();
      tx_pop = 1'b1; cyc(); tx_pop = 1'b0;
   endtask

   task automatic pop_rx();
      rx_pop = 1'b1; cyc(); rx_pop = 1'b0;
   endtask

   task automatic clr_all();
      rx_clr = 1'b1; tx_clr = 1'b1; cyc(); rx_clr = 1'b0; tx_clr = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();

      // R11 reset state
      chk("R11 rx_count", rx_count, 0);
      chk("R11 tx_count", tx_count, 0);
      chk("R11 full flags", {rx_full, tx_full}, 0);
      chk("R11 rx_req", rx_req, 0);
      chk("R11 tx_req", tx_req, 1);
      chk("R11 err_present", rx_err_present, 0);

      // R6 / R7 threshold table
      foreach (VEC[i]) begin
         clr_all();
         rx_trig_sel = VEC[i][7:6];
         tx_trig_sel = VEC[i][7:6];
         for (int k = 0; k < int'(VEC[i][5:1]); k++) begin
            if (VEC[i][8]) push_rx(8'(k), 3'b000);
            else           push_tx(8'(k));
         end
         #1;
         if (VEC[i][8]) begin
            chk($sformatf("R6 rx_req vec %0d", i), rx_req, VEC[i][0]);
            chk($sformatf("R1 rx_count vec %0d", i), rx_count, int'(VEC[i][5:1]) % 16);
            chk($sformatf("R1 rx_full vec %0d", i), rx_full, int'(VEC[i][5:1] == 5'd16));
         end else begin
            chk($sformatf("R7 tx_req vec %0d", i), tx_req, VEC[i][0]);
            chk($sformatf("R1 tx_count vec %0d", i), tx_count, int'(VEC[i][5:1]));
         end
      end
      rx_trig_sel = 2'd0;
      tx_trig_sel = 2'd0;

      // R1 / R2 order, drop on full, pop on empty
      clr_all();
      for (int k = 0; k < 17; k++) push_tx(8'(k * 3 + 1));
      chk("R1 tx_full at 16", tx_full, 1);
      chk("R1 tx_count at 16", tx_count, 0);
      for (int k = 0; k < 16; k++) begin
         chk($sformatf("R1 tx order %0d", k), tx_rd_data, k * 3 + 1);
         pop_tx();
      end
      chk("R2 extra push dropped", tx_count, 0);
      pop_tx();
      chk("R2 pop empty count", tx_count, 0);
      chk("R2 pop empty full", tx_full, 0);
      chk("R2 pop empty tx_req", tx_req, 1);

      // R3 / R9 error status and sticky present flag
      clr_all();
      push_rx(8'h41, 3'b000);
      push_rx(8'h42, 3'b001);
      push_rx(8'h43, 3'b000);
      push_rx(8'h44, 3'b100);
      chk("R9 present after errored push", rx_err_present, 1);
      chk("R3 clean head err", rx_rd_err, 0);
      pop_rx();
      chk("R3 parity bit1", rx_rd_err, 2);
      pop_rx();
      chk("R9 present while later error pending", rx_err_present, 1);
      pop_rx();
      chk("R3 break data", rx_rd_data, 8'h44);
      chk("R3 break bit3", rx_rd_err, 8);
      pop_rx();
      chk("R9 present after last error read", rx_err_present, 0);

      // R4 overrun marks newest entry
      clr_all();
      for (int k = 0; k < 16; k++) push_rx(8'(k), 3'b000);
      chk("R9 no error before overrun", rx_err_present, 0);
      push_rx(8'hEE, 3'b000);
      chk("R4 still full", rx_full, 1);
      chk("R4 overrun sets present", rx_err_present, 1);
      for (int k = 0; k < 15; k++) pop_rx();
      chk("R4 newest data kept", rx_rd_data, 15);
      chk("R4 newest has overrun bit0", rx_rd_err, 1);
      pop_rx();
      chk("R4 dropped byte absent", rx_count, 0);
      chk("R9 present cleared", rx_err_present, 0);

      // R5 push and pop together when full
      clr_all();
      for (int k = 0; k < 16; k++) push_tx(8'(k));
      tx_push = 1'b1; tx_pop = 1'b1; tx_wr_data = 8'h77;
      cyc();
      tx_push = 1'b0; tx_pop = 1'b0;
      chk("R5 still full", tx_full, 1);
      chk("R5 head advanced", tx_rd_data, 1);
      for (int k = 0; k < 15; k++) pop_tx();
      chk("R5 new byte stored last", tx_rd_data, 8'h77);

      // R8 separate flush, frame bit
      clr_all();
      for (int k = 0; k < 3; k++) push_tx(8'(k));
      push_rx(8'h55, 3'b010);
      chk("R3 frame bit2", rx_rd_err, 4);
      rx_clr = 1'b1; cyc(); rx_clr = 1'b0;
      chk("R8 rx flushed", rx_count, 0);
      chk("R8 present cleared", rx_err_present, 0);
      chk("R8 tx untouched", tx_count, 3);
      tx_clr = 1'b1; cyc(); tx_clr = 1'b0;
      chk("R8 tx flushed", tx_count, 0);

      // R10 disabled mode
      push_tx(8'h09);
      fifo_en = 1'b0;
      cyc();
      chk("R10 mode change flushes tx", tx_count, 0);
      push_rx(8'h11, 3'b000);
      chk("R10 rx full at one", rx_full, 1);
      chk("R10 rx count one", rx_count, 1);
      chk("R10 rx_req", rx_req, 1);
      push_rx(8'h22, 3'b000);
      chk("R10 held byte kept", rx_rd_data, 8'h11);
      chk("R10 overrun on held byte", rx_rd_err, 1);
      chk("R10 tx_req empty", tx_req, 1);
      push_tx(8'h33);
      chk("R10 tx full at one", tx_full, 1);
      chk("R10 tx_req busy", tx_req, 0);
      fifo_en = 1'b1;
      cyc();
      chk("R10 re-enable flushes rx", rx_count, 0);
      chk("R10 re-enable flushes tx", {tx_count, tx_full}, 0);
      chk("R10 re-enable clears present", rx_err_present, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule